// File: doc/BRIEF.md
# SPI FPGA Bitstream Configuration Sequencer

This block brings up an SRAM-based FPGA that takes its configuration over SPI as a slave. After a start pulse it pulls the target's active-low reset and its chip-select low together. It holds the reset for a timed interval, then releases it and confirms that the target's done flag has gone low. It keeps chip-select low through the long housekeeping wait the target needs, then raises chip-select briefly. Next it lowers chip-select again and shifts the image bytes out in SPI mode 0.

The image arrives on a valid/ready byte stream. `byte_ready` is high only while the sequencer is in its streaming phase and the shift register is empty. A byte moves in a cycle where `byte_valid` and `byte_ready` are both high. The source may hold `byte_valid` low for any number of cycles, which stalls the transfer without harm. Once a byte is offered, it and its `byte_last` flag must stay unchanged until the handshake. A byte taken with `byte_last` high ends the image.

After the image, the done flag must read high. The block then sends whole zero bytes that cover 49 clocks (7 bytes, 56 clocks) to start the loaded design. A 3-bit status output gives the outcome. All delays are counted in system clock cycles, derived from the clock frequency parameter.

Top module: `fpga_cfg_loader`

## Requirements
- R1: An accepted start (no partial request, valid parameters) drives `tgt_rst_n` and `tgt_cs_n` low in the same cycle. `tgt_rst_n` stays low for at least RESET_NS (1 µs default = 4 cycles at 4 MHz), and chip-select is low whenever reset is low.
- R2: After reset is released, the synchronised done flag is read once. If it is high, status becomes 3 (reset failure), chip-select is released, and no image byte is accepted.
- R3: Chip-select stays low for at least HOUSEKEEP_US (1200 µs default) after reset is released. It then goes high for at least one cycle and falls again before the first image bit, so a successful load lowers chip-select exactly twice.
- R4: Bytes are shifted MSB first in mode 0: SCLK idles low, the target samples MOSI on the rising edge, and MOSI changes only while SCLK is low. SCLK runs at CLK_HZ/(2·SCLK_DIV).
- R5: `byte_ready` is high only in the streaming phase while the shift register is empty. Bytes reach the target in handshake order and unaltered, whatever the gaps in `byte_valid`.
- R6: If the done flag reads low after the last image byte, status becomes 4 (configuration failure), chip-select is released, and no padding is sent.
- R7: After done is confirmed, 56 further SCLK cycles follow with MOSI low, with chip-select held low from the first image bit to the end of padding. Status then shows operating.
- R8: A start with `partial_req` high gives status 5 (not supported) and does not move `tgt_rst_n` or `tgt_cs_n`.
- R9: If SCLK_DIV places SCLK outside 1 MHz to 25 MHz, or CPHA is not 0, every start gives status 6 (parameter error) and leaves all target pins idle.
- R10: While a load runs, `busy` is 1 and status is 2. When idle with no error latched, status is 1 if the done flag is high and 0 otherwise. An error code stays until the next accepted start.
- R11: A start pulse while `busy` is high is ignored: the load in progress keeps its pins and reaches its normal result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load |
| partial_req | input | 1 | Qualifies start as a partial-reconfiguration request |
| byte_data | input | 8 | Image byte |
| byte_valid | input | 1 | Image byte offered |
| byte_last | input | 1 | Offered byte is the final image byte |
| byte_ready | output | 1 | Sequencer accepts a byte this cycle |
| done_in | input | 1 | Target done flag (asynchronous) |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_cs_n | output | 1 | Target chip-select, active low |
| tgt_sclk | output | 1 | SPI clock |
| tgt_mosi | output | 1 | SPI data to target |
| busy | output | 1 | Load in progress |
| status | output | 3 | 0 unknown, 1 operating, 2 busy, 3 reset fail, 4 config fail, 5 not supported, 6 parameter error |

## Verification
The main instance is built with CLK_HZ of 4 MHz and SCLK_DIV of 1. This shrinks the 1200 µs housekeeping wait to 4800 cycles, so several full loads fit in a short run. The reset pulse becomes a 4-cycle minimum whose width can be measured, and each bit takes two cycles. Two more instances share the clock: one with SCLK_DIV of 4, which puts SCLK below 1 MHz, and one with CPHA set to 1. These make both parameter-error paths reachable next to a legal build.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_UNKNOWN    = 3'd0,
    ST_OPERATING  = 3'd1,
    ST_BUSY       = 3'd2,
    ST_ERR_RESET  = 3'd3,
    ST_ERR_CONFIG = 3'd4,
    ST_NOT_SUPP   = 3'd5,
    ST_ERR_PARAM  = 3'd6
  } cfg_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST_HOLD,
    S_RST_CHECK,
    S_HOUSEKEEP,
    S_CS_GAP,
    S_STREAM,
    S_DONE_CHECK,
    S_PAD
  } seq_state_e;

  // Cycles of a clock at clk_hz covering ns nanoseconds, rounded up.
  function automatic longint ns_to_cycles(input longint clk_hz, input longint ns);
    return (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  localparam int N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[N-2+((N==1)?1:0):0] & {(N-1+((N==1)?1:0)){N != 1}}, d_in} | {{(N-1){1'b0}}, 1'b0};
  end

  assign q_out = chain[N-1];
endmodule

// File: rtl/cfg_delay_timer.sv
module cfg_delay_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/spi_tx_mode0.sv
module spi_tx_mode0 #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       sclk,
  output logic       mosi
);
  localparam int D  = (DIV < 1) ? 1 : DIV;
  localparam int DW = (D < 2) ? 1 : $clog2(D);

  logic          active;
  logic [7:0]    sr;
  logic [2:0]    bit_left;
  logic [DW-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sr       <= '0;
      bit_left <= '0;
      div_cnt  <= '0;
      sclk     <= 1'b0;
    end else if (!active) begin
      if (tx_valid) begin
        active   <= 1'b1;
        sr       <= tx_data;
        bit_left <= 3'd7;
        div_cnt  <= DW'(D - 1);
        sclk     <= 1'b0;
      end
    end else if (div_cnt != '0) begin
      div_cnt <= div_cnt - 1'b1;
    end else begin
      div_cnt <= DW'(D - 1);
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk <= 1'b0;
        if (bit_left == 3'd0) begin
          active <= 1'b0;
        end else begin
          sr       <= {sr[6:0], 1'b0};
          bit_left <= bit_left - 1'b1;
        end
      end
    end
  end

  assign tx_ready = !active;
  assign mosi     = active & sr[7];
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_loader_pkg::*;
#(
  parameter int TW         = 16,
  parameter int RST_CYC    = 100,
  parameter int SETTLE_CYC = 3,
  parameter int HK_CYC     = 1000,
  parameter int PAD_BYTES  = 7,
  parameter bit PARAM_OK   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          partial_req,
  input  logic          done_s,
  input  logic          tmr_zero,
  input  logic          byte_valid,
  input  logic          byte_last,
  input  logic          sh_ready,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          byte_ready,
  output logic          sh_valid,
  output logic          sh_pad,
  output logic          tgt_rst_n,
  output logic          tgt_cs_n,
  output logic          busy,
  output logic [2:0]    status
);
  localparam int PW = $clog2(PAD_BYTES + 1);

  seq_state_e  state, state_n;
  cfg_status_e result, result_n;
  logic [PW-1:0] pad_left, pad_n;
  logic          last_seen, last_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      result    <= ST_UNKNOWN;
      pad_left  <= '0;
      last_seen <= 1'b0;
    end else begin
      state     <= state_n;
      result    <= result_n;
      pad_left  <= pad_n;
      last_seen <= last_n;
    end
  end

  always_comb begin
    state_n  = state;
    result_n = result;
    pad_n    = pad_left;
    last_n   = last_seen;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          if (partial_req) begin
            result_n = ST_NOT_SUPP;
          end else if (!PARAM_OK) begin
            result_n = ST_ERR_PARAM;
          end else begin
            result_n = ST_UNKNOWN;
            state_n  = S_RST_HOLD;
            tmr_load = 1'b1;
            tmr_val  = TW'(RST_CYC);
            last_n   = 1'b0;
            pad_n    = PW'(PAD_BYTES);
          end
        end
      end
      S_RST_HOLD: begin
        if (tmr_zero) begin
          state_n  = S_RST_CHECK;
          tmr_load = 1'b1;
          tmr_val  = TW'(SETTLE_CYC);
        end
      end
      S_RST_CHECK: begin
        if (tmr_zero) begin
          if (done_s) begin
            result_n = ST_ERR_RESET;
            state_n  = S_IDLE;
          end else begin
            state_n  = S_HOUSEKEEP;
            tmr_load = 1'b1;
            tmr_val  = TW'(HK_CYC);
          end
        end
      end
      S_HOUSEKEEP: begin
        if (tmr_zero) begin
          state_n  = S_CS_GAP;
          tmr_load = 1'b1;
          tmr_val  = TW'(1);
        end
      end
      S_CS_GAP: begin
        if (tmr_zero) state_n = S_STREAM;
      end
      S_STREAM: begin
        if (byte_valid && byte_ready && byte_last) last_n = 1'b1;
        if (last_seen && sh_ready) state_n = S_DONE_CHECK;
      end
      S_DONE_CHECK: begin
        if (done_s) begin
          state_n = S_PAD;
        end else begin
          result_n = ST_ERR_CONFIG;
          state_n  = S_IDLE;
        end
      end
      S_PAD: begin
        if (sh_ready) begin
          if (pad_left == '0) begin
            state_n  = S_IDLE;
            result_n = ST_UNKNOWN;
          end else begin
            pad_n = pad_left - 1'b1;
          end
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  assign byte_ready = (state == S_STREAM) && sh_ready && !last_seen;
  assign sh_valid   = ((state == S_STREAM) && byte_valid && !last_seen) ||
                      ((state == S_PAD) && (pad_left != '0));
  assign sh_pad     = (state == S_PAD);
  assign tgt_rst_n  = (state != S_RST_HOLD);
  assign tgt_cs_n   = (state == S_IDLE) || (state == S_CS_GAP);
  assign busy       = (state != S_IDLE);

  always_comb begin
    if (busy)                     status = ST_BUSY;
    else if (result == ST_UNKNOWN) status = done_s ? ST_OPERATING : ST_UNKNOWN;
    else                          status = result;
  end
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int SCLK_DIV     = 4,
  parameter int CPHA         = 0,
  parameter int RESET_NS     = 1000,
  parameter int HOUSEKEEP_US = 1200,
  parameter int PAD_BITS     = 49,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       partial_req,
  input  logic [7:0] byte_data,
  input  logic       byte_valid,
  input  logic       byte_last,
  output logic       byte_ready,
  input  logic       done_in,
  output logic       tgt_rst_n,
  output logic       tgt_cs_n,
  output logic       tgt_sclk,
  output logic       tgt_mosi,
  output logic       busy,
  output logic [2:0] status
);
  localparam int DIV_EFF    = (SCLK_DIV < 1) ? 1 : SCLK_DIV;
  localparam int SCLK_HZ    = CLK_HZ / (2 * DIV_EFF);
  localparam bit PARAM_OK   = (CPHA == 0) && (SCLK_DIV >= 1) &&
                              (SCLK_HZ >= 1_000_000) && (SCLK_HZ <= 25_000_000);
  localparam int RST_RAW    = int'(ns_to_cycles(longint'(CLK_HZ), longint'(RESET_NS)));
  localparam int RST_CYC    = (RST_RAW < 1) ? 1 : RST_RAW;
  localparam int HK_CYC     = int'(ns_to_cycles(longint'(CLK_HZ), longint'(HOUSEKEEP_US) * 1000));
  localparam int SETTLE_CYC = SYNC_STAGES + 1;
  localparam int PAD_BYTES  = (PAD_BITS + 7) / 8;
  localparam int TMR_MAX    = ((HK_CYC > RST_CYC) ? HK_CYC : RST_CYC) + SETTLE_CYC + 2;
  localparam int TW         = $clog2(TMR_MAX + 1);

  logic          done_s;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          sh_valid, sh_ready, sh_pad;
  logic [7:0]    sh_data;

  cfg_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(clk), .rst_n(rst_n), .d_in(done_in), .q_out(done_s)
  );

  cfg_delay_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  assign sh_data = sh_pad ? 8'h00 : byte_data;

  spi_tx_mode0 #(.DIV(DIV_EFF)) u_shift (
    .clk(clk), .rst_n(rst_n), .tx_valid(sh_valid), .tx_data(sh_data),
    .tx_ready(sh_ready), .sclk(tgt_sclk), .mosi(tgt_mosi)
  );

  cfg_seq_fsm #(
    .TW(TW), .RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC), .HK_CYC(HK_CYC),
    .PAD_BYTES(PAD_BYTES), .PARAM_OK(PARAM_OK)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .partial_req(partial_req),
    .done_s(done_s), .tmr_zero(tmr_zero), .byte_valid(byte_valid),
    .byte_last(byte_last), .sh_ready(sh_ready), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .byte_ready(byte_ready), .sh_valid(sh_valid),
    .sh_pad(sh_pad), .tgt_rst_n(tgt_rst_n), .tgt_cs_n(tgt_cs_n),
    .busy(busy), .status(status)
  );
endmodule

// File: rtl/cfg_loader_checks.sv
module cfg_loader_checks
  import cfg_loader_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int RESET_NS = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_rst_n,
  input logic       tgt_cs_n,
  input logic       tgt_sclk,
  input logic       tgt_mosi,
  input logic       byte_ready,
  input logic       busy,
  input logic [2:0] status
);
  localparam int RST_MIN = int'(ns_to_cycles(longint'(CLK_HZ), longint'(RESET_NS)));

  logic [31:0] lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lo_cnt <= '0;
    else if (!tgt_rst_n) lo_cnt <= lo_cnt + 1'b1;
    else                 lo_cnt <= '0;
  end

  a_r1_cs_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> !tgt_cs_n);

  a_r1_reset_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_rst_n) |-> (lo_cnt >= 32'(RST_MIN)));

  a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sclk && $past(tgt_sclk)) |-> $stable(tgt_mosi));

  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_cs_n |-> !tgt_sclk);

  a_r5_ready_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (busy && !tgt_cs_n && tgt_rst_n));

  a_r10_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status == ST_BUSY));

  a_r10_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status != ST_BUSY));

  a_r9_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tgt_cs_n && tgt_rst_n));
endmodule

bind fpga_cfg_loader cfg_loader_checks #(.CLK_HZ(CLK_HZ), .RESET_NS(RESET_NS)) u_checks (
  .clk(clk), .rst_n(rst_n), .tgt_rst_n(tgt_rst_n), .tgt_cs_n(tgt_cs_n),
  .tgt_sclk(tgt_sclk), .tgt_mosi(tgt_mosi), .byte_ready(byte_ready),
  .busy(busy), .status(status)
);

// File: tb/test_fpga_cfg_loader.sv
module test_fpga_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 4_000_000;
  localparam int RST_MIN_TB = 4;      // 1 us at 4 MHz
  localparam int HK_MIN_TB  = 4800;   // 1200 us at 4 MHz
  localparam int PAD_TB     = 7;      // 49 bits -> 7 bytes

  // partial, done@reset, done@stream, poke, nbytes[4], exp status[3], exp cs falls[2]
  localparam logic [12:0] VEC [0:4] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 3'd5, 2'd0},
    {1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 3'd1, 2'd2},
    {1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 3'd3, 2'd1},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 3'd4, 2'd2},
    {1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 3'd1, 2'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, partial_req = 1'b0, start_bad = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_valid = 1'b0, byte_last = 1'b0, done_in = 1'b0;
  logic byte_ready, tgt_rst_n, tgt_cs_n, tgt_sclk, tgt_mosi, busy;
  logic [2:0] status;

  logic b1_ready, b1_rst_n, b1_cs_n, b1_sclk, b1_mosi, b1_busy;
  logic [2:0] b1_status;
  logic b2_ready, b2_rst_n, b2_cs_n, b2_sclk, b2_mosi, b2_busy;
  logic [2:0] b2_status;

  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpga_cfg_loader #(.CLK_HZ(TB_CLK_HZ), .SCLK_DIV(1)) i_fpga_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .partial_req(partial_req),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_last(byte_last),
    .byte_ready(byte_ready), .done_in(done_in), .tgt_rst_n(tgt_rst_n),
    .tgt_cs_n(tgt_cs_n), .tgt_sclk(tgt_sclk), .tgt_mosi(tgt_mosi),
    .busy(busy), .status(status));

  fpga_cfg_loader #(.CLK_HZ(TB_CLK_HZ), .SCLK_DIV(4)) i_bad_div (
    .clk(clk), .rst_n(rst_n), .start(start_bad), .partial_req(1'b0),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_last(byte_last),
    .byte_ready(b1_ready), .done_in(done_in), .tgt_rst_n(b1_rst_n),
    .tgt_cs_n(b1_cs_n), .tgt_sclk(b1_sclk), .tgt_mosi(b1_mosi),
    .busy(b1_busy), .status(b1_status));

  fpga_cfg_loader #(.CLK_HZ(TB_CLK_HZ), .SCLK_DIV(1), .CPHA(1)) i_bad_cpha (
    .clk(clk), .rst_n(rst_n), .start(start_bad), .partial_req(1'b0),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_last(byte_last),
    .byte_ready(b2_ready), .done_in(done_in), .tgt_rst_n(b2_rst_n),
    .tgt_cs_n(b2_cs_n), .tgt_sclk(b2_sclk), .tgt_mosi(b2_mosi),
    .busy(b2_busy), .status(b2_status));

  // Target model: captures MOSI on rising SCLK while selected.
  logic [7:0] rx_buf [0:63];
  logic [7:0] rx_sr = '0;
  int rx_n = 0, rx_bits = 0;
  always @(posedge tgt_sclk) begin
    if (!tgt_cs_n) begin
      rx_sr = {rx_sr[6:0], tgt_mosi};
      rx_bits++;
      if (rx_bits == 8) begin
        if (rx_n < 64) rx_buf[rx_n] = rx_sr;
        rx_n++;
        rx_bits = 0;
      end
    end
  end

  // Pin monitors, sampled away from the active edge.
  int cs_falls = 0, rst_falls = 0, rst_cur = 0, rst_w = 0, hk_len = 0, hk_w = 0;
  int b_falls = 0;
  logic cs_prev = 1'b1, rst_prev = 1'b1, hk_on = 1'b0;
  always @(negedge clk) begin
    if (cs_prev && !tgt_cs_n) cs_falls++;
    if (rst_prev && !tgt_rst_n) rst_falls++;
    if (!b1_cs_n || !b1_rst_n || !b2_cs_n || !b2_rst_n) b_falls++;
    if (!tgt_rst_n) rst_cur++;
    else if (!rst_prev) begin
      rst_w = rst_cur; rst_cur = 0; hk_on = 1'b1; hk_len = 0;
    end
    if (hk_on) begin
      if (tgt_cs_n) begin hk_on = 1'b0; hk_w = hk_len; end
      else hk_len++;
    end
    cs_prev  = tgt_cs_n;
    rst_prev = tgt_rst_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int c, input int i);
    return 8'(8'h5A + 8'(i * 29) + 8'(c * 71));
  endfunction

  task automatic run_case(input int c, input logic [12:0] v);
    bit partial = v[12], dres = v[11], dstr = v[10], poke = v[9];
    int n = int'(v[8:5]);
    int exp_st = int'(v[4:2]);
    int exp_cf = int'(v[1:0]);
    int cf0, rx0, rf0, idx, gap, cyc;
    bit hs;
    done_in = dres;
    repeat (5) @(negedge clk);
    cf0 = cs_falls; rx0 = rx_n; rf0 = rst_falls;
    start = 1'b1; partial_req = partial;
    @(negedge clk);
    start = 1'b0; partial_req = 1'b0;
    idx = 0; gap = 0; cyc = 0;
    if (!partial) begin
      byte_valid = 1'b1; byte_data = pat(c, 0); byte_last = (n == 1);
    end
    while (busy) begin
      hs = byte_valid && byte_ready;
      @(negedge clk);
      cyc++;
      if (hs) begin
        idx++;
        byte_valid = 1'b0;
        if (idx == n) done_in = dstr;
        else gap = 6;          // R5: back-pressure gap between bytes
      end else if (gap > 0) begin
        gap--;
        if (gap == 0) begin
          byte_valid = 1'b1; byte_data = pat(c, idx); byte_last = (idx == n - 1);
        end
      end
      if (poke && cyc == 200) begin start = 1'b1; partial_req = 1'b1; end
      if (poke && cyc == 201) begin
        start = 1'b0; partial_req = 1'b0;
        chk(busy && status == 3'd2, "R11 start while busy ignored", int'(status), 2);
        chk(!tgt_cs_n, "R11 cs kept low after busy start", int'(tgt_cs_n), 0);
      end
    end
    byte_valid = 1'b0; byte_last = 1'b0;
    repeat (4) @(negedge clk);
    chk(status == 3'(exp_st), $sformatf("R10 case %0d status", c), int'(status), exp_st);
    chk(cs_falls - cf0 == exp_cf, $sformatf("R3 case %0d cs falls", c), cs_falls - cf0, exp_cf);
    if (partial)
      chk(rst_falls == rf0, "R8 reset pin untouched", rst_falls - rf0, 0);
    if (exp_st == 3 || exp_st == 4)
      chk(rx_n == rx0 + ((exp_st == 4) ? n : 0), $sformatf("R2 R6 case %0d bytes sent", c),
          rx_n - rx0, (exp_st == 4) ? n : 0);
    if (exp_st == 1) begin
      chk(rx_n - rx0 == n + PAD_TB, "R7 byte count with padding", rx_n - rx0, n + PAD_TB);
      for (int i = 0; i < n; i++)
        chk(rx_buf[rx0 + i] == pat(c, i), "R5 R4 image byte MSB first",
            int'(rx_buf[rx0 + i]), int'(pat(c, i)));
      for (int i = 0; i < PAD_TB; i++)
        chk(rx_buf[rx0 + n + i] == 8'h00, "R7 padding zero", int'(rx_buf[rx0 + n + i]), 0);
      chk(rx_bits == 0, "R7 whole padding bytes", rx_bits, 0);
    end
    if (c == 1) begin
      chk(rst_w >= RST_MIN_TB && rst_w <= RST_MIN_TB + 2, "R1 reset width", rst_w, RST_MIN_TB);
      chk(hk_w >= HK_MIN_TB && hk_w <= HK_MIN_TB + 20, "R3 housekeeping wait", hk_w, HK_MIN_TB);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state
    chk(status == 3'd0, "R10 reset status unknown", int'(status), 0);
    chk(!busy, "R10 reset not busy", int'(busy), 0);
    chk(tgt_rst_n && tgt_cs_n, "R1 pins idle after reset", int'({tgt_rst_n, tgt_cs_n}), 3);
    chk(!byte_ready, "R5 no ready when idle", int'(byte_ready), 0);
    chk(!tgt_sclk, "R4 sclk idle low", int'(tgt_sclk), 0);
    done_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(status == 3'd1, "R10 idle operating with done high", int'(status), 1);
    done_in = 1'b0;

    for (int c = 0; c < 5; c++) run_case(c, VEC[c]);

    // R9: parameter-error builds
    repeat (2) @(negedge clk);
    start_bad = 1'b1;
    @(negedge clk);
    start_bad = 1'b0;
    repeat (20) @(negedge clk);
    chk(b1_status == 3'd6, "R9 divider out of range", int'(b1_status), 6);
    chk(b2_status == 3'd6, "R9 cpha rejected", int'(b2_status), 6);
    chk(b_falls == 0, "R9 pins untouched", b_falls, 0);
    chk(!b1_busy && !b2_busy, "R9 not busy", int'({b1_busy, b2_busy}), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule